// File: doc/BRIEF.md
# Daisy-Chain Interrupt Responder

This block raises an interrupt request on one fixed priority level and answers the matching acknowledge cycle on a shared backplane. Local logic pulses `raise_req` to post a request, and the block then holds its active-low request line asserted. When an acknowledge cycle arrives, the block looks at three things. The first is its pending state. The second is the 3-bit level code on the low address lines. The third is the incoming daisy-chain grant. From these it either answers the cycle or hands the grant on to the next slot.

When it answers, the block drives the 8-bit status/ID byte that local logic offers. It asserts the data-valid strobe until the data strobe or the address strobe is released. When the address strobe goes high, the request is retired. In every other case, the incoming low grant is forwarded to the downstream chain output.

All bus inputs pass through a synchronizer of configurable depth. The respond-or-forward decision is taken once per acknowledge cycle and held until the address strobe is released. The address-modifier lines, the second data strobe and the write line play no part in the decision.

Top module: `chain_irq_responder`

## Requirements
- R1: Out of reset, `irq_n`, `iackout_n` and `dtack_n` are high, `data_oe` is 0 and `data_out` is 0.
- R2: A one-cycle pulse on `raise_req` drives `irq_n` low within SYNC_STAGES+3 cycles. `irq_n` stays low until an acknowledge cycle that this block answers has completed.
- R3: `iackout_n` is high whenever the synchronized `iackin_n` is high.
- R4: The block answers when all of the following hold: `iack_n` is low, `as_n` is low, `ds0_n` is low, `iackin_n` is low, a request is pending, and `lvl_code` equals parameter LEVEL. Answering means `dtack_n` goes low, `data_oe` goes high, `data_out` carries `status_id`, and `iackout_n` stays high.
- R5: A pending block seeing a `lvl_code` different from LEVEL forwards the grant: `iackout_n` goes low, `dtack_n` stays high and `data_oe` stays 0.
- R6: A block with no request pending forwards the grant even when `lvl_code` equals LEVEL.
- R7: With `iack_n` high, the block neither answers nor forwards (`dtack_n` and `iackout_n` stay high). The value on `am` never changes any output.
- R8: The decision is latched when the acknowledge cycle starts. Later changes of `lvl_code` while `as_n` stays low do not change whether the block answers or forwards.
- R9: Once `ds0_n` returns high while `as_n` is still low, `dtack_n` returns high and `data_oe` returns to 0.
- R10: When `as_n` returns high after an answered cycle, `irq_n` returns high. After a forwarded cycle, `irq_n` stays low.
- R11: The status byte is captured at the decision. Later changes of `status_id` during the same cycle do not alter `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_req | input | 1 | Local one-cycle pulse that posts a request |
| status_id | input | 8 | Status/ID byte offered by local logic |
| irq_n | output | 1 | Active-low interrupt request for level LEVEL |
| iack_n | input | 1 | Active-low acknowledge-cycle indicator |
| as_n | input | 1 | Active-low address strobe |
| ds0_n | input | 1 | Active-low low-byte data strobe |
| lvl_code | input | 3 | Level code from address lines 1 to 3 |
| am | input | 6 | Address modifier lines (ignored) |
| iackin_n | input | 1 | Incoming daisy-chain grant, active low |
| iackout_n | output | 1 | Outgoing daisy-chain grant, active low |
| data_out | output | 8 | Status byte on the low data lines |
| data_oe | output | 1 | Output enable for `data_out` |
| dtack_n | output | 1 | Active-low data-valid strobe |

## Verification
The bench builds the block with LEVEL=5 and SYNC_STAGES=2. This lets the random cycles hit matching codes as well as the codes directly above and below 5. The random stimulus mixes pending and idle states, acknowledge and plain cycles, arbitrary address-modifier values and arbitrary status bytes. Directed cases then move the level code and the status byte in the middle of a cycle to exercise R8 and R11. They also release the data strobe before the address strobe to exercise R9.

// File: rtl/cir_pkg.sv
package cir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RESP = 2'd1,
    ST_PASS = 2'd2
  } ack_state_e;
endpackage

// File: rtl/cir_sync.sv
module cir_sync #(
  parameter int W       = 7,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= RST_VAL;
          else        stg_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[i] <= RST_VAL;
          else        stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cir_request.sv
module cir_request (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic retire,
  output logic pending
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_en = raise | retire;
    pend_d  = raise ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pending = pend_q;

  // R10
  retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !raise) |=> !pend_q);
  // R2
  raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> pend_q);
endmodule

// File: rtl/cir_ack_fsm.sv
module cir_ack_fsm
  import cir_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int ID_W  = 8,
  parameter logic [LVL_W-1:0] LEVEL = 3'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_act,
  input  logic             as_act,
  input  logic             ds_act,
  input  logic             chain_act,
  input  logic [LVL_W-1:0] lvl,
  input  logic             pending,
  input  logic [ID_W-1:0]  id_in,
  output logic             resp_drive,
  output logic             chain_fwd,
  output logic [ID_W-1:0]  id_q,
  output logic             retire
);
  ack_state_e       st_q, st_d;
  logic [ID_W-1:0]  id_d;
  logic             id_en;
  logic             start;

  always_comb begin
    st_d  = st_q;
    start = as_act && iack_act && chain_act;
    id_en = 1'b0;
    id_d  = id_in;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (pending && (lvl == LEVEL)) begin
            st_d  = ST_RESP;
            id_en = 1'b1;
          end else begin
            st_d = ST_PASS;
          end
        end
      end
      ST_RESP, ST_PASS: begin
        if (!as_act) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (id_en) id_q <= id_d;
  end

  assign retire     = (st_q == ST_RESP) && !as_act;
  assign resp_drive = (st_q == ST_RESP) && as_act && ds_act;
  assign chain_fwd  = (st_q == ST_PASS) && chain_act;

  // R8
  decision_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != ST_IDLE) && as_act) |=> $stable(st_q));
  // R7
  idle_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && !as_act) |=> (st_q == ST_IDLE));
  // R11
  id_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESP) |=> $stable(id_q));
endmodule

// File: rtl/chain_irq_responder.sv
module chain_irq_responder #(
  parameter int LVL_W       = 3,
  parameter int ID_W        = 8,
  parameter int AM_W        = 6,
  parameter int SYNC_STAGES = 2,
  parameter logic [LVL_W-1:0] LEVEL = 3'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_req,
  input  logic [ID_W-1:0]  status_id,
  output logic             irq_n,
  input  logic             iack_n,
  input  logic             as_n,
  input  logic             ds0_n,
  input  logic [LVL_W-1:0] lvl_code,
  input  logic [AM_W-1:0]  am,
  input  logic             iackin_n,
  output logic             iackout_n,
  output logic [ID_W-1:0]  data_out,
  output logic             data_oe,
  output logic             dtack_n
);
  localparam int BUS_W = LVL_W + 4;

  logic [BUS_W-1:0] bus_raw, bus_s;
  logic             iack_s, as_s, ds0_s, iackin_s;
  logic [LVL_W-1:0] lvl_s;
  logic             pending, retire, resp_drive, chain_fwd;
  logic [ID_W-1:0]  id_q;
  logic             am_unused;

  assign am_unused = ^am;
  assign bus_raw   = {iack_n, as_n, ds0_n, iackin_n, lvl_code};

  cir_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign {iack_s, as_s, ds0_s, iackin_s, lvl_s} = bus_s;

  cir_request u_req (
    .clk(clk), .rst_n(rst_n), .raise(raise_req), .retire(retire), .pending(pending)
  );

  cir_ack_fsm #(.LVL_W(LVL_W), .ID_W(ID_W), .LEVEL(LEVEL)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .iack_act(!iack_s), .as_act(!as_s), .ds_act(!ds0_s), .chain_act(!iackin_s),
    .lvl(lvl_s), .pending(pending), .id_in(status_id),
    .resp_drive(resp_drive), .chain_fwd(chain_fwd), .id_q(id_q), .retire(retire)
  );

  assign irq_n     = !pending;
  assign dtack_n   = !resp_drive;
  assign data_oe   = resp_drive;
  assign data_out  = resp_drive ? id_q : '0;
  assign iackout_n = !chain_fwd;

  // R3
  chain_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iackin_s |-> iackout_n);
  // R4
  answer_or_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !iackout_n));
  // R4
  answer_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> !irq_n);
  // R7
  answer_needs_iack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !iack_s);
endmodule

// File: tb/sim_chain_irq_responder.sv
module sim_chain_irq_responder;
  localparam int LEVEL = 5;
  localparam int WAITC = 6;

  logic clk = 1'b0;
  logic rst_n, raise_req, iack_n, as_n, ds0_n, iackin_n;
  logic [7:0] status_id, data_out;
  logic [2:0] lvl_code;
  logic [5:0] am;
  logic irq_n, iackout_n, data_oe, dtack_n;

  int checks = 0;
  int fails  = 0;
  bit exp_pend = 0;
  bit done = 0;

  always #10 clk = ~clk;

  chain_irq_responder #(.SYNC_STAGES(2), .LEVEL(3'(LEVEL))) u0 (
    .clk(clk), .rst_n(rst_n), .raise_req(raise_req), .status_id(status_id),
    .irq_n(irq_n), .iack_n(iack_n), .as_n(as_n), .ds0_n(ds0_n),
    .lvl_code(lvl_code), .am(am), .iackin_n(iackin_n), .iackout_n(iackout_n),
    .data_out(data_out), .data_oe(data_oe), .dtack_n(dtack_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic bit will_answer(input bit pend, input bit iack_on, input logic [2:0] lv);
    return pend && iack_on && (lv == 3'(LEVEL));
  endfunction

  task automatic raise();
    raise_req = 1'b1; cyc(1); raise_req = 1'b0; cyc(3);
    exp_pend = 1'b1;
  endtask

  task automatic idle_bus();
    iack_n = 1; as_n = 1; ds0_n = 1; iackin_n = 1;
  endtask

  // full acknowledge cycle with checks at each phase
  task automatic ack_cycle(input logic [2:0] lv, input bit iack_on, input logic [7:0] id);
    bit ans, fwd;
    ans = will_answer(exp_pend, iack_on, lv);
    fwd = iack_on && !ans;
    status_id = id; lvl_code = lv; am = 6'($urandom);
    iack_n = !iack_on; iackin_n = 0; as_n = 0; ds0_n = 0;
    cyc(WAITC);
    chk(dtack_n == !ans, ans ? "R4 dtack" : "R5/R6/R7 dtack", dtack_n, !ans);
    chk(data_oe == ans, "R4 data_oe", data_oe, ans);
    if (ans) chk(data_out == id, "R4 data_out", data_out, id);
    chk(iackout_n == !fwd, fwd ? "R5/R6 iackout" : "R7 iackout", iackout_n, !fwd);
    am = 6'($urandom);
    cyc(2);
    chk(dtack_n == !ans && iackout_n == !fwd, "R7 am ignored", {dtack_n, iackout_n}, {!ans, !fwd});
    ds0_n = 1;
    cyc(WAITC);
    chk(dtack_n && !data_oe, "R9 release", {dtack_n, data_oe}, 2'b10);
    idle_bus();
    cyc(WAITC);
    if (ans) exp_pend = 0;
    chk(irq_n == !exp_pend, "R10 irq after cycle", irq_n, !exp_pend);
    chk(iackout_n, "R3 chain high", iackout_n, 1);
  endtask

  initial begin
    rst_n = 0; raise_req = 0; status_id = 0; lvl_code = 0; am = 0;
    idle_bus();
    void'($urandom(32'd20240611));
    cyc(3);
    chk(irq_n && iackout_n && dtack_n && !data_oe && data_out == 0, "R1 reset",
        {irq_n, iackout_n, dtack_n, data_oe}, 4'b1110);
    rst_n = 1;
    cyc(3);
    chk(irq_n, "R1 idle irq", irq_n, 1);

    // R2: raise and hold
    raise();
    chk(!irq_n, "R2 irq low", irq_n, 0);
    cyc(20);
    chk(!irq_n, "R2 irq held", irq_n, 0);

    // R3: chain high while iack cycle with iackin high
    iack_n = 0; as_n = 0; ds0_n = 0; lvl_code = 3'd2; iackin_n = 1;
    cyc(WAITC);
    chk(iackout_n, "R3 iackin high", iackout_n, 1);
    idle_bus(); cyc(WAITC);

    // directed: mismatch below/above, match, no pending
    ack_cycle(3'd4, 1, 8'h11);
    ack_cycle(3'd6, 1, 8'h22);
    ack_cycle(3'(LEVEL), 1, 8'hA5);
    ack_cycle(3'(LEVEL), 1, 8'h3C);   // R6 no request pending
    raise();
    ack_cycle(3'(LEVEL), 0, 8'h77);   // R7 plain cycle

    // R8 + R11: answer latched, then move level and byte
    lvl_code = 3'(LEVEL); status_id = 8'h5A;
    iack_n = 0; iackin_n = 0; as_n = 0; ds0_n = 0;
    cyc(WAITC);
    lvl_code = 3'd1; status_id = 8'hFF;
    cyc(WAITC);
    chk(!dtack_n && iackout_n, "R8 answer held", {dtack_n, iackout_n}, 2'b01);
    chk(data_out == 8'h5A, "R11 byte held", data_out, 8'h5A);
    idle_bus(); cyc(WAITC); exp_pend = 0;
    chk(irq_n, "R10 retired", irq_n, 1);

    // R8: forward latched, then level moves to match
    raise();
    lvl_code = 3'd2;
    iack_n = 0; iackin_n = 0; as_n = 0; ds0_n = 0;
    cyc(WAITC);
    lvl_code = 3'(LEVEL);
    cyc(WAITC);
    chk(dtack_n && !iackout_n, "R8 forward held", {dtack_n, iackout_n}, 2'b10);
    idle_bus(); cyc(WAITC);
    chk(!irq_n, "R10 still pending", irq_n, 0);

    // random mix
    for (int k = 0; k < 120; k++) begin
      if ($urandom_range(0, 2) == 0 && !exp_pend) raise();
      ack_cycle(3'($urandom_range(3, 7)), bit'($urandom_range(0, 4) != 0), 8'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule